// File: doc/BRIEF.md
# Less-Than Flag Decoder

This block turns the status bits of a subtraction into the result of a "set if less than" instruction. It does not compare the operands itself. The arithmetic unit next to it computes A − B, and this block reads four bits from that subtraction: the top bit of A, the top bit of B, the top bit of the difference, and the adder's carry out. From these bits it decides whether A is below B, reading the operands either as two's-complement or as unsigned numbers.

The two-bit operation code shares its encoding with the arithmetic unit's subtract codes. Code 2'b10 selects the signed comparison and code 2'b11 selects the unsigned one, so that whenever this block's answer is selected, the adder is performing the matching subtraction. The result is a full data word: the decision sits in bit 0 and every other bit is zero. The ALU's result multiplexer can pass this word through directly. Both decisions are built side by side, and the code chooses between them. The block is purely combinational and has no state.

Top module: `slt_flag_unit`

## Requirements
- R1: With op_sel = 2'b10 (signed) and a_msb different from b_msb, lt_word[0] equals a_msb: a negative A is below a non-negative B, and never the other way round.
- R2: With op_sel = 2'b10 and a_msb equal to b_msb, lt_word[0] equals diff_msb, the top bit of A − B.
- R3: With op_sel = 2'b11 (unsigned), lt_word[0] is 1 exactly when sub_carry is 0, because a missing carry out of A + ~B + 1 marks a borrow.
- R4: Bits WORD_W−1 down to 1 of lt_word are 0 for every input combination.
- R5: With op_sel = 2'b00 or 2'b01, lt_word is all zeros, whatever the four flag bits are.
- R6: The unsigned result does not depend on a_msb, b_msb or diff_msb, and the signed result does not depend on sub_carry.
- R7: When the four flags come from a real A − B on WORD_W-bit operands, lt_word[0] matches the true signed (code 2'b10) or unsigned (code 2'b11) ordering of A and B, including at the most negative and most positive values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation code: 2'b10 signed, 2'b11 unsigned, 2'b0x gives a zero word |
| a_msb | input | 1 | Top (sign) bit of operand A |
| b_msb | input | 1 | Top (sign) bit of operand B |
| diff_msb | input | 1 | Top bit of the A − B result from the adder |
| sub_carry | input | 1 | Carry out of the adder while it forms A + ~B + 1 |
| lt_word | output | WORD_W | Comparison result in bit 0, zeros above it |

## Verification
The hardest case to reach is one where the flags are consistent with each other but the answer depends on only one of them. Examples are a signed pair with opposite signs whose difference overflows, such as the most negative value minus a positive value, or an unsigned pair where A and B differ only in the top bit. A sweep over all 64 flag and code combinations covers every row of the decision table, including combinations that a real adder never produces. A second sweep forms the flags the way an adder would, from pairs of boundary operands, and compares the result with the ordering computed directly in the bench.

// File: rtl/slt_flag_pkg.sv
// Shared definitions for the less-than flag decoder.
// Assumes the operation code is shared with the subtract codes of the
// neighbouring arithmetic unit, so its encoding must not be changed.
package slt_flag_pkg;

    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOGIC_SLOT = 2'b00,
        OPC_ARITH_SLOT = 2'b01,
        OPC_LT_SIGNED  = 2'b10,
        OPC_LT_UNSIGN  = 2'b11
    } slt_opc_e;

endpackage

// File: rtl/slt_signed_decide.sv
// Signed less-than decision made from the flags of A - B.
// Assumes the flags come from a two's-complement subtraction. When the
// operand signs agree, that subtraction cannot overflow, so the sign of
// the difference is trustworthy only in that case.
module slt_signed_decide (
    input  logic a_msb,
    input  logic b_msb,
    input  logic diff_msb,
    output logic lt
);

    // Purpose: pick the operand sign when the signs differ, else the difference sign.
    always_comb begin
        if (a_msb != b_msb) begin
            lt = a_msb;
        end else begin
            lt = diff_msb;
        end
        // R1: a negative A against a non-negative B is always below it.
        a_r1_neg_below_pos : assert (!(a_msb && !b_msb) || lt)
            else $error("signed: negative A not reported below non-negative B");
        // R1: a non-negative A against a negative B is never below it.
        a_r1_pos_not_below_neg : assert (!(!a_msb && b_msb) || !lt)
            else $error("signed: non-negative A reported below negative B");
    end

endmodule

// File: rtl/slt_unsigned_decide.sv
// Unsigned less-than decision made from the adder carry.
// Assumes the subtraction is formed as A + ~B + 1. Under that form a
// carry out of 0 means a borrow occurred, which means A < B.
module slt_unsigned_decide (
    input  logic sub_carry,
    output logic lt
);

    // Purpose: a borrow (no carry out) marks A below B.
    always_comb begin
        lt = (sub_carry == 1'b0);
    end

endmodule

// File: rtl/slt_word_pack.sv
// Places a single decision bit in bit 0 of a data word and zero-fills the rest.
// Assumes WORD_W >= 2. When bit_en is low the whole word is forced to zero.
module slt_word_pack #(
    parameter int WORD_W = 32
) (
    input  logic              bit_in,
    input  logic              bit_en,
    output logic [WORD_W-1:0] word_out
);

    localparam int FILL_W = WORD_W - 1;

    // Purpose: bit 0 carries the gated decision, all higher lanes are tied low.
    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        if (g == 0) begin : g_lsb
            assign word_out[g] = bit_in & bit_en;
        end else begin : g_fill
            assign word_out[g] = 1'b0;
        end
    end

    // Purpose: check the zero fill above bit 0.
    always_comb begin
        // R4: nothing but bit 0 may ever be set.
        a_r4_upper_zero : assert (word_out[WORD_W-1:1] == {FILL_W{1'b0}})
            else $error("upper bits of result word not zero");
    end

endmodule

// File: rtl/slt_flag_unit.sv
// Less-than flag decoder: builds the signed and the unsigned decision side
// by side from the flags of a shared A - B, and selects one of them with
// the operation code. Codes 2'b0x produce an all-zero word.
// Assumes the flags belong to the subtraction currently selected by the
// arithmetic unit, which uses the same code. Purely combinational.
module slt_flag_unit
    import slt_flag_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [OPC_W-1:0]  op_sel,
    input  logic              a_msb,
    input  logic              b_msb,
    input  logic              diff_msb,
    input  logic              sub_carry,
    output logic [WORD_W-1:0] lt_word
);

    slt_opc_e opc;
    logic     lt_signed;
    logic     lt_unsigned;
    logic     lt_pick;
    logic     lt_valid;

    // Purpose: give the raw code its enumerated type.
    always_comb begin
        opc = slt_opc_e'(op_sel);
    end

    slt_signed_decide u_signed (
        .a_msb    (a_msb),
        .b_msb    (b_msb),
        .diff_msb (diff_msb),
        .lt       (lt_signed)
    );

    slt_unsigned_decide u_unsigned (
        .sub_carry (sub_carry),
        .lt        (lt_unsigned)
    );

    // Purpose: choose the decision for the selected comparison kind.
    always_comb begin
        lt_pick  = 1'b0;
        lt_valid = 1'b0;
        unique case (opc)
            OPC_LT_SIGNED: begin
                lt_pick  = lt_signed;
                lt_valid = 1'b1;
            end
            OPC_LT_UNSIGN: begin
                lt_pick  = lt_unsigned;
                lt_valid = 1'b1;
            end
            default: begin
                lt_pick  = 1'b0;
                lt_valid = 1'b0;
            end
        endcase
    end

    slt_word_pack #(
        .WORD_W (WORD_W)
    ) u_pack (
        .bit_in   (lt_pick),
        .bit_en   (lt_valid),
        .word_out (lt_word)
    );

    // Purpose: check the selected result against the port-level rules.
    always_comb begin
        // R5: codes outside the comparison pair give an all-zero word.
        a_r5_idle_codes_zero : assert (op_sel[1] || (lt_word == '0))
            else $error("non-compare code produced a nonzero word");
        // R2: matching signs pass the difference sign through.
        a_r2_same_sign_follows_diff : assert (!(opc == OPC_LT_SIGNED && a_msb == b_msb)
                                              || (lt_word[0] == diff_msb))
            else $error("signed same-sign result differs from difference sign");
        // R3: unsigned result is the complement of the carry.
        a_r3_borrow_means_less : assert (opc != OPC_LT_UNSIGN || (lt_word[0] != sub_carry))
            else $error("unsigned result does not track the borrow");
    end

endmodule

// File: tb/slt_flag_unit_tb_top.sv
// Bench: exhaustive sweep over code and flags, then flags formed from real
// subtractions of boundary operands against a directly computed ordering.
module slt_flag_unit_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [1:0]   op_sel;
    logic         a_msb, b_msb, diff_msb, sub_carry;
    logic [W-1:0] lt_word;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    slt_flag_unit #(.WORD_W(W)) dut_i (
        .op_sel    (op_sel),
        .a_msb     (a_msb),
        .b_msb     (b_msb),
        .diff_msb  (diff_msb),
        .sub_carry (sub_carry),
        .lt_word   (lt_word)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s op=%b a=%b b=%b d=%b c=%b actual=%h expected=%h",
                     req, op_sel, a_msb, b_msb, diff_msb, sub_carry, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [3:0] f);
        @(posedge clk);
        op_sel    = op;
        a_msb     = f[3];
        b_msb     = f[2];
        diff_msb  = f[1];
        sub_carry = f[0];
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] vals [8];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h8000_0001;
        vals[6] = 32'h0000_00FF; vals[7] = 32'hFFFF_FFF3;

        // Initial state: all inputs low, idle code.
        drive(2'b00, 4'b0000);
        check("R5 initial", lt_word, '0);

        // Exhaustive sweep over code and the four flags.
        for (int op = 0; op < 4; op++) begin
            for (int f = 0; f < 16; f++) begin
                logic e;
                logic [3:0] fl;
                fl = 4'(f);
                drive(2'(op), fl);
                check("R4 upper bits", {lt_word[W-1:1], 1'b0}, '0);
                if (op < 2) begin
                    check("R5 idle code", lt_word, '0);
                end else if (op == 2) begin
                    if (fl[3] != fl[2]) begin
                        e = fl[3];
                        check("R1 signed differing signs", lt_word, {{(W-1){1'b0}}, e});
                    end else begin
                        e = fl[1];
                        check("R2 signed same signs", lt_word, {{(W-1){1'b0}}, e});
                    end
                    // R6: carry ignored in signed mode (flip it, same answer).
                    drive(2'b10, {fl[3:1], ~fl[0]});
                    check("R6 signed ignores carry", lt_word, {{(W-1){1'b0}}, e});
                end else begin
                    e = ~fl[0];
                    check("R3 unsigned borrow", lt_word, {{(W-1){1'b0}}, e});
                    // R6: sign flags ignored in unsigned mode.
                    drive(2'b11, {~fl[3:1], fl[0]});
                    check("R6 unsigned ignores signs", lt_word, {{(W-1){1'b0}}, e});
                end
            end
        end

        // Flags formed as an adder would, compared with true ordering.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [W:0]   sum;
                logic [W-1:0] a, b;
                logic         es, eu;
                a   = vals[i];
                b   = vals[j];
                sum = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
                es  = ($signed(a) < $signed(b));
                eu  = (a < b);
                drive(2'b10, {a[W-1], b[W-1], sum[W-1], sum[W]});
                check("R7 signed ordering", lt_word, {{(W-1){1'b0}}, es});
                drive(2'b11, {a[W-1], b[W-1], sum[W-1], sum[W]});
                check("R7 unsigned ordering", lt_word, {{(W-1){1'b0}}, eu});
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

endmodule